// File: doc/BRIEF.md
# Strap Latch and Clock Output Controller

This block is the digital control core of a multi-output system clock generator. After reset it takes one sample of four frequency-select straps and one mode strap. These straps share pins that carry clocks afterwards, so they are never sampled again. From that point on it combines the latched straps with the contents of six 8-bit control registers, which a serial host interface maintains elsewhere, and with the stop and power-down inputs. From these it produces a registered gate for every clock output, a global tristate control, the spread-spectrum controls and the 4-bit frequency code for the synthesizer.

The mode strap decides what three shared pins do. With mode 1 they are the first three SDRAM clock outputs. With mode 0 they are the CPU-stop, PCI-stop and power-down inputs, all active low. Each output group (CPU, SDRAM, PCI, fixed-frequency) changes its gates only in a cycle where that group's low-phase indicator is high, so a clock never stops or restarts in the middle of a high pulse. Three read-back bytes return the register contents with the inverted strap values placed in the fields a host expects.

Top module: `clkgen_ctrl`

## Requirements
- R1: The strap pins and the mode pin are captured on the first rising clock edge after reset is released and are never sampled again until the next reset. Later activity on those pins has no effect on any output.
- R2: Read-back bytes carry the inverted latched straps: `rb_cpu_o[7]` = not FS2, `rb_fix_o[6]` = not FS0, `rb_sdh_o[3]` = not FS1, `rb_sdh_o[1]` = not FS3. Every other bit passes the matching register bit through.
- R3: The frequency code follows the selected source. When `cfg_ctl_i[3]` = 0 it is the latched straps FS3..FS0. When `cfg_ctl_i[3]` = 1 it is {`cfg_ctl_i[2]`, `cfg_ctl_i[6:4]`}. The code is registered, so it appears one cycle after the inputs.
- R4: `freq_upd_o` is high for exactly the one cycle in which `freq_code_o` takes a new value, and low in every cycle where the code does not change.
- R5: `tristate_o` follows `cfg_ctl_i[0]` one cycle later, once the straps are latched.
- R6: `ss_en_o` follows `cfg_ctl_i[1]`. `ss_mode_o` is 2 (0.5 % down) when `cfg_cpu_i[5]` = 0. Otherwise it is 1 (0.75 % centre) when `cfg_ctl_i[7]` = 1, and 0 (0.5 % centre) when that bit is 0.
- R7: Each output has its own active-high enable. CPU k is `cfg_cpu_i[k+1]`. PCI k is `cfg_pci_i[k]`. SDRAM 0..7 are `cfg_sdl_i[7:0]`. SDRAM 8..13 are `cfg_sdh_i` bits 0, 2, 4, 5, 6, 7. REF0/REF1 are `cfg_fix_i[0]`/`[1]`, 48 MHz is `cfg_fix_i[5]` and 24/48 MHz is `cfg_fix_i[4]`. `sio_24m_o` follows `cfg_fix_i[7]`.
- R8: With the latched mode at 1, `pins_in_o` is 0, the stop and power-down inputs are ignored, and SDRAM 0..2 follow their enables.
- R9: With the latched mode at 0, `pins_in_o` is 1 and SDRAM 0..2 stay gated off. The CPU-stop input low gates all CPU and SDRAM clocks except CPU 0 and SDRAM 12.
- R10: With the latched mode at 0, the PCI-stop input low gates every PCI clock except PCI 0.
- R11: With the latched mode at 0, the power-down input low gates every output, and the previous gating returns when it rises again.
- R12: A group's gates (phase bit 0 CPU, 1 SDRAM, 2 PCI, 3 fixed) update only on an edge where its `phase_lo_i` bit is high, and otherwise hold.
- R13: During reset and in the cycle that latches the straps, all gates, `freq_code_o` and `freq_upd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| fs_pin_i | input | 4 | Frequency-select strap pins FS3..FS0 |
| mode_pin_i | input | 1 | Mode strap pin |
| cpu_stop_n_i | input | 1 | CPU-stop input, active low (mode 0 only) |
| pci_stop_n_i | input | 1 | PCI-stop input, active low (mode 0 only) |
| pwrdn_n_i | input | 1 | Power-down input, active low (mode 0 only) |
| phase_lo_i | input | 4 | Low-phase indicator per group: CPU, SDRAM, PCI, fixed |
| cfg_ctl_i | input | 8 | Control register: source, code, spread, tristate |
| cfg_cpu_i | input | 8 | CPU enables and down-spread select |
| cfg_pci_i | input | 8 | PCI enables |
| cfg_fix_i | input | 8 | Fixed-clock enables and 24/48 select |
| cfg_sdh_i | input | 8 | SDRAM 8..13 enables |
| cfg_sdl_i | input | 8 | SDRAM 0..7 enables |
| pins_in_o | output | 1 | Shared pins act as inputs (latched mode 0) |
| cpu_gate_o | output | 3 | CPU clock gates |
| sdram_gate_o | output | 14 | SDRAM clock gates |
| pci_gate_o | output | 7 | PCI clock gates |
| ref_gate_o | output | 2 | Reference clock gates |
| usb_gate_o | output | 1 | 48 MHz clock gate |
| sio_gate_o | output | 1 | 24/48 MHz clock gate |
| sio_24m_o | output | 1 | 24/48 output runs at 24 MHz when 1 |
| tristate_o | output | 1 | Tristate all clock outputs |
| freq_code_o | output | 4 | Frequency code to the synthesizer |
| freq_upd_o | output | 1 | One-cycle strobe on a frequency code change |
| ss_en_o | output | 1 | Spread spectrum enable |
| ss_mode_o | output | 2 | Spread mode: 0 centre 0.5 %, 1 centre 0.75 %, 2 down 0.5 % |
| rb_cpu_o | output | 8 | Read-back of the CPU register with not FS2 |
| rb_fix_o | output | 8 | Read-back of the fixed register with not FS0 |
| rb_sdh_o | output | 8 | Read-back of SDRAM 8..13 register with not FS1/FS3 |

## Verification
The straps are tried in two power-up cycles with opposite mode and complementary frequency values. This shows whether the sample is truly taken once and whether the shared pins switch role. Stop and power-down pulses are applied under both modes: under mode 1 they must change nothing, and under mode 0 each one removes exactly its own set of outputs and spares the free-running ones. Sparse enable patterns with alternating bits expose any swapped mapping. Holding one phase bit low while the enables change shows whether the gates hold. A long random phase then drives every input, strap pins included, against a behavioural model on every cycle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int REG_W    = 8;
  localparam int FS_W     = 4;
  localparam int N_CPU    = 3;
  localparam int N_SDRAM  = 14;
  localparam int N_PCI    = 7;
  localparam int N_FIX    = 4;
  localparam int N_GROUP  = 4;
  localparam int N_SHARED = 3;

  // control register fields
  localparam int C_TRI   = 0;
  localparam int C_SSEN  = 1;
  localparam int C_SSEL3 = 2;
  localparam int C_SWSEL = 3;
  localparam int C_SSLO  = 4;
  localparam int C_WIDE  = 7;
  // cpu register field
  localparam int K_CENTER = 5;
  // fixed register field
  localparam int F_SEL24 = 7;

  // group order in phase_lo
  localparam int G_CPU = 0;
  localparam int G_SD  = 1;
  localparam int G_PCI = 2;
  localparam int G_FIX = 3;

  typedef enum logic [1:0] {
    SS_CTR_HALF  = 2'd0,
    SS_CTR_3Q    = 2'd1,
    SS_DOWN_HALF = 2'd2
  } ss_mode_e;
endpackage

// File: rtl/clkctl_strap_latch.sv
module clkctl_strap_latch #(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_pin_i,
  input  logic            mode_pin_i,
  output logic [FS_W-1:0] fs_o,
  output logic            mode_o,
  output logic            done_o
);
  logic [FS_W-1:0] fs_q, fs_d;
  logic            mode_q, mode_d, done_q, done_d;

  always_comb begin
    fs_d   = fs_q;
    mode_d = mode_q;
    done_d = done_q;
    if (!done_q) begin
      fs_d   = fs_pin_i;
      mode_d = mode_pin_i;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      fs_q   <= fs_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  assign fs_o   = fs_q;
  assign mode_o = mode_q;
  assign done_o = done_q;
endmodule

// File: rtl/clkctl_freq_sel.sv
module clkctl_freq_sel #(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            live_i,
  input  logic            sw_sel_i,
  input  logic [FS_W-1:0] sw_code_i,
  input  logic [FS_W-1:0] hw_code_i,
  output logic [FS_W-1:0] code_o,
  output logic            upd_o
);
  logic [FS_W-1:0] code_q, code_d, sel;
  logic            upd_q, upd_d;

  always_comb begin
    sel    = sw_sel_i ? sw_code_i : hw_code_i;
    code_d = live_i ? sel : code_q;
    upd_d  = live_i && (sel != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/clkctl_gate_group.sv
module clkctl_gate_group #(
  parameter int           W         = 4,
  parameter logic [W-1:0] FREE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en_i,
  input  logic         live_i,
  input  logic         stop_i,
  input  logic         pd_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] block_i,
  output logic [W-1:0] gate_o
);
  logic [W-1:0] want, gate_q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign want[k] = live_i & en_i[k] & ~block_i[k] & ~pd_i
                   & ~(stop_i & ~FREE_MASK[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else if (upd_en_i) begin
      gate_q <= want;
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkctl_pkg::*;
#(
  parameter int FREE_CPU = 0,
  parameter int FREE_SD  = 12,
  parameter int FREE_PCI = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  fs_pin_i,
  input  logic        mode_pin_i,
  input  logic        cpu_stop_n_i,
  input  logic        pci_stop_n_i,
  input  logic        pwrdn_n_i,
  input  logic [3:0]  phase_lo_i,
  input  logic [7:0]  cfg_ctl_i,
  input  logic [7:0]  cfg_cpu_i,
  input  logic [7:0]  cfg_pci_i,
  input  logic [7:0]  cfg_fix_i,
  input  logic [7:0]  cfg_sdh_i,
  input  logic [7:0]  cfg_sdl_i,
  output logic        pins_in_o,
  output logic [2:0]  cpu_gate_o,
  output logic [13:0] sdram_gate_o,
  output logic [6:0]  pci_gate_o,
  output logic [1:0]  ref_gate_o,
  output logic        usb_gate_o,
  output logic        sio_gate_o,
  output logic        sio_24m_o,
  output logic        tristate_o,
  output logic [3:0]  freq_code_o,
  output logic        freq_upd_o,
  output logic        ss_en_o,
  output logic [1:0]  ss_mode_o,
  output logic [7:0]  rb_cpu_o,
  output logic [7:0]  rb_fix_o,
  output logic [7:0]  rb_sdh_o
);
  localparam logic [N_CPU-1:0]   CPU_FREE = N_CPU'(1) << FREE_CPU;
  localparam logic [N_SDRAM-1:0] SD_FREE  = N_SDRAM'(1) << FREE_SD;
  localparam logic [N_PCI-1:0]   PCI_FREE = N_PCI'(1) << FREE_PCI;

  logic [FS_W-1:0] fs_lat;
  logic            mode_lat, strap_done;
  logic            mode0, cpu_stop, pci_stop, pd;

  clkctl_strap_latch #(.FS_W(FS_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .fs_pin_i(fs_pin_i), .mode_pin_i(mode_pin_i),
    .fs_o(fs_lat), .mode_o(mode_lat), .done_o(strap_done)
  );

  // shared pins become active-low control inputs only in mode 0
  assign mode0    = strap_done & ~mode_lat;
  assign cpu_stop = mode0 & ~cpu_stop_n_i;
  assign pci_stop = mode0 & ~pci_stop_n_i;
  assign pd       = mode0 & ~pwrdn_n_i;

  clkctl_freq_sel #(.FS_W(FS_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .live_i(strap_done),
    .sw_sel_i(cfg_ctl_i[C_SWSEL]),
    .sw_code_i({cfg_ctl_i[C_SSEL3], cfg_ctl_i[C_SSLO+2:C_SSLO]}),
    .hw_code_i(fs_lat),
    .code_o(freq_code_o), .upd_o(freq_upd_o)
  );

  logic [N_SDRAM-1:0] sd_en, sd_block;
  logic [N_FIX-1:0]   fix_en, fix_gate;

  assign sd_en    = {cfg_sdh_i[7], cfg_sdh_i[6], cfg_sdh_i[5], cfg_sdh_i[4],
                     cfg_sdh_i[2], cfg_sdh_i[0], cfg_sdl_i};
  assign sd_block = {{(N_SDRAM-N_SHARED){1'b0}}, {N_SHARED{mode0}}};
  assign fix_en   = {cfg_fix_i[4], cfg_fix_i[5], cfg_fix_i[1], cfg_fix_i[0]};

  clkctl_gate_group #(.W(N_CPU), .FREE_MASK(CPU_FREE)) u_cpu (
    .clk(clk), .rst_n(rst_n), .upd_en_i(phase_lo_i[G_CPU]), .live_i(strap_done),
    .stop_i(cpu_stop), .pd_i(pd), .en_i(cfg_cpu_i[N_CPU:1]),
    .block_i('0), .gate_o(cpu_gate_o)
  );

  clkctl_gate_group #(.W(N_SDRAM), .FREE_MASK(SD_FREE)) u_sd (
    .clk(clk), .rst_n(rst_n), .upd_en_i(phase_lo_i[G_SD]), .live_i(strap_done),
    .stop_i(cpu_stop), .pd_i(pd), .en_i(sd_en),
    .block_i(sd_block), .gate_o(sdram_gate_o)
  );

  clkctl_gate_group #(.W(N_PCI), .FREE_MASK(PCI_FREE)) u_pci (
    .clk(clk), .rst_n(rst_n), .upd_en_i(phase_lo_i[G_PCI]), .live_i(strap_done),
    .stop_i(pci_stop), .pd_i(pd), .en_i(cfg_pci_i[N_PCI-1:0]),
    .block_i('0), .gate_o(pci_gate_o)
  );

  clkctl_gate_group #(.W(N_FIX), .FREE_MASK('1)) u_fix (
    .clk(clk), .rst_n(rst_n), .upd_en_i(phase_lo_i[G_FIX]), .live_i(strap_done),
    .stop_i(1'b0), .pd_i(pd), .en_i(fix_en),
    .block_i('0), .gate_o(fix_gate)
  );

  assign ref_gate_o = fix_gate[1:0];
  assign usb_gate_o = fix_gate[2];
  assign sio_gate_o = fix_gate[3];

  // misc control registers
  logic     tri_q, tri_d, ssen_q, ssen_d, sel24_q, sel24_d;
  ss_mode_e ssm_q, ssm_d;

  always_comb begin
    tri_d   = strap_done & cfg_ctl_i[C_TRI];
    ssen_d  = strap_done & cfg_ctl_i[C_SSEN];
    sel24_d = phase_lo_i[G_FIX] ? cfg_fix_i[F_SEL24] : sel24_q;
    if (!cfg_cpu_i[K_CENTER])   ssm_d = SS_DOWN_HALF;
    else if (cfg_ctl_i[C_WIDE]) ssm_d = SS_CTR_3Q;
    else                        ssm_d = SS_CTR_HALF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q   <= 1'b0;
      ssen_q  <= 1'b0;
      sel24_q <= 1'b0;
      ssm_q   <= SS_CTR_HALF;
    end else begin
      tri_q   <= tri_d;
      ssen_q  <= ssen_d;
      sel24_q <= sel24_d;
      ssm_q   <= ssm_d;
    end
  end

  assign tristate_o = tri_q;
  assign ss_en_o    = ssen_q;
  assign sio_24m_o  = sel24_q;
  assign ss_mode_o  = ssm_q;
  assign pins_in_o  = mode0;

  // read-back with inverted strap fields
  assign rb_cpu_o = {~fs_lat[2], cfg_cpu_i[6:0]};
  assign rb_fix_o = {cfg_fix_i[7], ~fs_lat[0], cfg_fix_i[5:0]};
  assign rb_sdh_o = {cfg_sdh_i[7:4], ~fs_lat[1], cfg_sdh_i[2], ~fs_lat[3], cfg_sdh_i[0]};

  logic unused_bits;
  assign unused_bits = ^{cfg_pci_i[7]};
endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strap_done,
  input logic        pins_in_o,
  input logic        pwrdn_n_i,
  input logic [3:0]  phase_lo_i,
  input logic [2:0]  cpu_gate_o,
  input logic [13:0] sdram_gate_o,
  input logic [6:0]  pci_gate_o,
  input logic [3:0]  freq_code_o,
  input logic        freq_upd_o
);
  a_r4_upd_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    freq_upd_o |-> (freq_code_o != $past(freq_code_o)));

  a_r4_no_upd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code_o == $past(freq_code_o)) |-> !freq_upd_o);

  a_r12_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_lo_i[0] |=> $stable(cpu_gate_o));

  a_r12_pci_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_lo_i[2] |=> $stable(pci_gate_o));

  a_r1_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> (strap_done && $stable(pins_in_o)));

  a_r11_pd_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_in_o && !pwrdn_n_i && phase_lo_i[0]) |=> (cpu_gate_o == 3'b000));

  a_r13_dark_before_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (cpu_gate_o == '0 && sdram_gate_o == '0 && pci_gate_o == '0
                     && freq_code_o == '0));
endmodule

bind clkgen_ctrl clkgen_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strap_done(strap_done), .pins_in_o(pins_in_o),
  .pwrdn_n_i(pwrdn_n_i), .phase_lo_i(phase_lo_i), .cpu_gate_o(cpu_gate_o),
  .sdram_gate_o(sdram_gate_o), .pci_gate_o(pci_gate_o),
  .freq_code_o(freq_code_o), .freq_upd_o(freq_upd_o)
);

// File: tb/clkgen_ctrl_bench.sv
`timescale 1ns/1ps
module clkgen_ctrl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [3:0]  fs_pin;
  logic        mode_pin, cs_n, ps_n, pd_n;
  logic [3:0]  phase;
  logic [7:0]  r0, r1, r2, r3, r4, r5;
  logic        pins_in, usb_g, sio_g, sel24, tri_o, upd, ssen;
  logic [2:0]  cpu_g;
  logic [13:0] sd_g;
  logic [6:0]  pci_g;
  logic [1:0]  ref_g, ssm;
  logic [3:0]  code;
  logic [7:0]  rb1, rb3, rb4;

  clkgen_ctrl u_clkgen_ctrl (
    .clk(clk), .rst_n(rst_n), .fs_pin_i(fs_pin), .mode_pin_i(mode_pin),
    .cpu_stop_n_i(cs_n), .pci_stop_n_i(ps_n), .pwrdn_n_i(pd_n), .phase_lo_i(phase),
    .cfg_ctl_i(r0), .cfg_cpu_i(r1), .cfg_pci_i(r2), .cfg_fix_i(r3),
    .cfg_sdh_i(r4), .cfg_sdl_i(r5), .pins_in_o(pins_in), .cpu_gate_o(cpu_g),
    .sdram_gate_o(sd_g), .pci_gate_o(pci_g), .ref_gate_o(ref_g), .usb_gate_o(usb_g),
    .sio_gate_o(sio_g), .sio_24m_o(sel24), .tristate_o(tri_o), .freq_code_o(code),
    .freq_upd_o(upd), .ss_en_o(ssen), .ss_mode_o(ssm), .rb_cpu_o(rb1),
    .rb_fix_o(rb3), .rb_sdh_o(rb4)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic        m_done, m_mode, m_upd, m_tri, m_ssen, m_sel24;
  logic [3:0]  m_fs, m_code, m_fix;
  logic [2:0]  m_cpu;
  logic [13:0] m_sd;
  logic [6:0]  m_pci;
  logic [1:0]  m_ssm;

  function automatic logic sd_en(int i);
    if (i < 8) return r5[i];
    case (i)
      8:  return r4[0];
      9:  return r4[2];
      10: return r4[4];
      11: return r4[5];
      12: return r4[6];
      default: return r4[7];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_mode = 0; m_upd = 0; m_tri = 0; m_ssen = 0; m_sel24 = 0;
      m_fs = 0; m_code = 0; m_fix = 0; m_cpu = 0; m_sd = 0; m_pci = 0; m_ssm = 0;
    end else begin
      bit live, mz, pd, cs, ps;
      logic [3:0] nxt;
      live = m_done;
      mz = m_done && !m_mode;
      pd = mz && !pd_n; cs = mz && !cs_n; ps = mz && !ps_n;
      if (phase[0])
        for (int i = 0; i < 3; i++) m_cpu[i] = live && r1[i+1] && !pd && !(cs && i != 0);
      if (phase[1])
        for (int i = 0; i < 14; i++)
          m_sd[i] = live && sd_en(i) && !pd && !(cs && i != 12) && !(mz && i < 3);
      if (phase[2])
        for (int i = 0; i < 7; i++) m_pci[i] = live && r2[i] && !pd && !(ps && i != 0);
      if (phase[3]) begin
        m_fix[0] = live && r3[0] && !pd;
        m_fix[1] = live && r3[1] && !pd;
        m_fix[2] = live && r3[5] && !pd;
        m_fix[3] = live && r3[4] && !pd;
        m_sel24  = r3[7];
      end
      nxt = r0[3] ? {r0[2], r0[6:4]} : m_fs;
      m_upd = live && (nxt != m_code);
      if (live) m_code = nxt;
      m_tri  = live && r0[0];
      m_ssen = live && r0[1];
      m_ssm  = !r1[5] ? 2'd2 : (r0[7] ? 2'd1 : 2'd0);
      if (!m_done) begin
        m_fs = fs_pin; m_mode = mode_pin; m_done = 1;
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    check("R7 cpu gates", cpu_g, m_cpu);
    check("R7 sdram gates", sd_g, m_sd);
    check("R7 pci gates", pci_g, m_pci);
    check("R7 fixed gates", {sio_g, usb_g, ref_g}, m_fix);
    check("R7 24m select", sel24, m_sel24);
    check("R3 freq code", code, m_code);
    check("R4 update strobe", upd, m_upd);
    check("R5 tristate", tri_o, m_tri);
    check("R6 spread enable", ssen, m_ssen);
    check("R6 spread mode", ssm, m_ssm);
    check("R8 pin role", pins_in, m_done && !m_mode);
    check("R2 rb cpu", rb1, {~m_fs[2], r1[6:0]});
    check("R2 rb fix", rb3, {r3[7], ~m_fs[0], r3[5:0]});
    check("R2 rb sdh", rb4, {r4[7:4], ~m_fs[1], r4[2], ~m_fs[3], r4[0]});
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic power_up(logic [3:0] fs, logic md);
    rst_n = 0; fs_pin = fs; mode_pin = md;
    tick(2);
    check("R13 gates in reset", {cpu_g, sd_g, pci_g, code, upd}, 0);
    rst_n = 1;
    tick(1);
    // straps latched on this edge; gates still dark
    check("R13 gates at latch", {cpu_g, sd_g, pci_g, code, upd}, 0);
    fs_pin = ~fs; mode_pin = ~md;   // pins now carry clocks
    tick(2);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    cs_n = 1; ps_n = 1; pd_n = 1; phase = 4'hF;
    r0 = 0; r1 = 8'hFF; r2 = 8'hFF; r3 = 8'hFF; r4 = 8'hFF; r5 = 8'hFF;
    rst_n = 0; fs_pin = 0; mode_pin = 0;
    tick(1);
    cmp_on = 1;

    // --- mode 1 power-up ---
    power_up(4'b1010, 1'b1);
    check("R1 straps kept (code)", code, 4'b1010);
    check("R2 not FS2", rb1[7], 1'b1);
    check("R2 not FS0 / FS1 / FS3", {rb3[6], rb4[3], rb4[1]}, 3'b100);
    check("R8 pins are outputs", pins_in, 1'b0);
    cs_n = 0; ps_n = 0; pd_n = 0;
    tick(2);
    check("R8 stops ignored cpu", cpu_g, 3'b111);
    check("R8 stops ignored sdram", sd_g, 14'h3FFF);
    check("R8 stops ignored pci", pci_g, 7'h7F);
    cs_n = 1; ps_n = 1; pd_n = 1;

    r2 = 8'h55; r5 = 8'h00; r4 = 8'b1010_0101;
    tick(2);
    check("R7 pci map", pci_g, 7'h55);
    check("R7 sdram map", sd_g, {6'b101011, 8'h00});

    r0 = 8'b0110_1000;
    tick(1);
    check("R3 sw code", code, 4'b0110);
    check("R4 strobe high", upd, 1'b1);
    tick(1);
    check("R4 strobe one cycle", upd, 1'b0);

    r0 = 8'b1110_1011;
    tick(1);
    check("R5 tristate", tri_o, 1'b1);
    check("R6 centre wide", {ssen, ssm}, {1'b1, 2'd1});
    r1[5] = 0;
    tick(1);
    check("R6 down overrides", ssm, 2'd2);

    phase = 4'b1110; r1 = 8'h00;
    tick(3);
    check("R12 cpu gates held", cpu_g, 3'b111);
    phase = 4'hF;
    tick(1);
    check("R12 cpu gates follow", cpu_g, 3'b000);

    // --- mode 0 power-up ---
    r0 = 0; r1 = 8'hFF; r2 = 8'hFF; r3 = 8'hFF; r4 = 8'hFF; r5 = 8'hFF;
    power_up(4'b0101, 1'b0);
    check("R9 pins are inputs", pins_in, 1'b1);
    check("R9 shared sdram off", sd_g[2:0], 3'b000);
    check("R1 second capture", code, 4'b0101);
    cs_n = 0;
    tick(2);
    check("R9 cpu stop cpu", cpu_g, 3'b001);
    check("R9 cpu stop sdram", sd_g, 14'h1000);
    cs_n = 1; ps_n = 0;
    tick(2);
    check("R10 pci stop", pci_g, 7'h01);
    ps_n = 1; pd_n = 0;
    tick(2);
    check("R11 power down", {cpu_g, sd_g, pci_g, ref_g, usb_g, sio_g}, 0);
    pd_n = 1;
    tick(2);
    check("R11 restore", {cpu_g, pci_g}, {3'b111, 7'h7F});

    // --- random phase, model compared every cycle ---
    for (int k = 0; k < 3000; k++) begin
      if (k == 1500) power_up($urandom, $urandom);
      fs_pin = $urandom; mode_pin = $urandom;
      cs_n = $urandom; ps_n = $urandom; pd_n = ($urandom % 4) != 0;
      phase = $urandom;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      r3 = $urandom; r4 = $urandom; r5 = $urandom;
      tick(1 + ($urandom % 3));
    end

    cmp_on = 0;
    summary();
    $finish;
  end
endmodule